// File: doc/BRIEF.md
# Speculative Line Tracking Cache Set

This block holds the tags and line state of a single 4-way set of a first-level cache. It adds two marks to every line so that the set can support a hardware transactional region. One mark records that the region read the line speculatively. The other records that the region wrote the line speculatively. The marks are tracked per whole line. They steer the choice of victim, decide whether a speculative miss overflows the set, make a non-speculative miss bypass the set, and catch an illegal store that mixes access types. They also let an incoming coherence snoop detect a conflict with the running region.

Each cycle the set takes at most one operation: an ordinary load or store, a speculative load or store, a release hint, or a snoop. A snoop can either keep the snooped copy or invalidate it. All lookups, the snoop reply and the status pulses are answered combinationally in the cycle of the request, and the line state updates at the next clock edge. Three further inputs act on the whole set:

- `commit` makes the region's effects permanent.
- `abort` rolls the region back.
- `nack_mode` is held during the commit drain. While it is high, conflicting snoops are refused instead of being reported.

The data array, the lower cache level and the coherence fabric lie outside the block. A miss installs its tag in the chosen way in the same cycle.

Top module: `spec_line_set`

## Requirements
- R1: After reset no line is valid, and every status output is low while `req_valid` is low. The first access misses and selects way 0.
- R2: An access whose tag matches a valid line raises `hit` with that line's way on `hit_way`. A miss that is allowed to allocate installs the tag in `victim_way`, and a later access to the same tag hits there. Operation codes on `req_op` are: 0 load, 1 store, 2 speculative load, 3 speculative store, 4 release, 5 keeping snoop, 6 invalidating snoop.
- R3: The victim is chosen in this order:
  1. The lowest-numbered invalid way.
  2. Otherwise the tree pseudo-LRU way, provided it is unmarked.
  3. Otherwise the pseudo-LRU pick from the other half of the set, provided it is unmarked.
  4. Otherwise the lowest-numbered unmarked way.

  A marked way is never chosen while an unmarked way exists.
- R4: A speculative miss when every way carries a mark raises `overflow` for one cycle and installs nothing.
- R5: A non-speculative miss when every way carries a mark raises `bypass`, does not raise `overflow`, and installs nothing.
- R6: `writeback` rises in two cases. The first is a speculative store, outside nack mode, that hits a dirty line without a write mark. The second is an allocation that evicts a dirty valid line. A speculative store to a clean line does not raise it.
- R7: While `in_region` is high, a non-speculative store that hits a marked line raises `fault`, and the store is dropped. A non-speculative load of such a line is allowed.
- R8: An invalidating snoop conflicts with a line that has either mark. A keeping snoop conflicts only with a write-marked line. Outside nack mode a conflict raises `conflict`, and `snoop_ack_hit` stays low as if the line were absent.
- R9: While `nack_mode` is high, a conflicting snoop raises `snoop_nack` instead of `conflict` and leaves the line intact. A speculative store made in nack mode does not set the write mark.
- R10: `commit` clears every mark and keeps every line valid.
- R11: `abort` invalidates every write-marked line, keeps read-only-marked lines valid, and clears every mark.
- R12: A release clears the read mark of the matching line only when that line has no write mark. Otherwise the release is ignored.
- R13: A snoop that does not conflict raises `snoop_ack_hit` exactly when the tag is present. An invalidating snoop also removes the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_region | input | 1 | A transactional region is running |
| nack_mode | input | 1 | Refuse conflicting snoops (commit drain) |
| commit | input | 1 | Clear all marks |
| abort | input | 1 | Drop write-marked lines, clear all marks |
| req_valid | input | 1 | Operation present this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_tag | input | TAG_W | Line tag of the operation |
| hit | output | 1 | Access hit |
| hit_way | output | 2 | Way of the matching line |
| miss | output | 1 | Access missed |
| victim_way | output | 2 | Way chosen for allocation |
| overflow | output | 1 | Speculative capacity overflow |
| bypass | output | 1 | Non-speculative miss served around the set |
| writeback | output | 1 | Committed dirty data must be written below |
| fault | output | 1 | Illegal non-speculative store to a marked line |
| conflict | output | 1 | Snoop hit region state |
| snoop_nack | output | 1 | Snoop refused in nack mode |
| snoop_ack_hit | output | 1 | Snoop reply: line present |

## Verification
The assertions rest on four assumptions about the inputs:
- `commit` and `abort` arrive as single pulses with `req_valid` low.
- At most one operation is presented per cycle.
- `nack_mode` changes only between operations.
- No tag is ever valid in two ways at once. The block guarantees this itself, because it installs only on a miss.

The stimulus keeps within these assumptions: each operation is driven for exactly one cycle from the falling edge, and global commands are issued in their own idle cycles.

// File: rtl/spec_line_set.sv
module spec_line_set #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_region,
  input  logic             nack_mode,
  input  logic             commit,
  input  logic             abort,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit,
  output logic [1:0]       hit_way,
  output logic             miss,
  output logic [1:0]       victim_way,
  output logic             overflow,
  output logic             bypass,
  output logic             writeback,
  output logic             fault,
  output logic             conflict,
  output logic             snoop_nack,
  output logic             snoop_ack_hit
);
  localparam int WAYS = 4;
  localparam logic [2:0] OP_ST = 3'd1, OP_SLD = 3'd2, OP_SST = 3'd3,
                         OP_REL = 3'd4, OP_SNR = 3'd5, OP_SNI = 3'd6;

  logic [WAYS-1:0]  vld_q, drt_q, sr_q, sw_q, match, marked;
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [2:0]       plru_q;
  logic [1:0]       hw, first_inv, first_unm, p1, p2;

  always_comb begin
    for (int w = 0; w < WAYS; w++) match[w] = vld_q[w] && (tag_q[w] == req_tag);
  end

  assign marked = sr_q | sw_q;

  wire is_acc     = req_valid && !req_op[2];
  wire is_spec    = req_op[1];
  wire is_snp     = req_valid && (req_op == OP_SNR || req_op == OP_SNI);
  wire is_rel     = req_valid && (req_op == OP_REL);
  wire hit_any    = |match;
  wire all_marked = &marked;

  always_comb begin
    hw = '0; first_inv = '0; first_unm = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (match[w])   hw = 2'(w);
      if (!vld_q[w])  first_inv = 2'(w);
      if (!marked[w]) first_unm = 2'(w);
    end
  end

  assign p1 = plru_q[0] ? {1'b1, plru_q[2]} : {1'b0, plru_q[1]};
  assign p2 = plru_q[0] ? {1'b0, plru_q[1]} : {1'b1, plru_q[2]};

  always_comb begin
    if (!(&vld_q))        victim_way = first_inv;
    else if (!marked[p1]) victim_way = p1;
    else if (!marked[p2]) victim_way = p2;
    else                  victim_way = first_unm;
  end

  wire alloc = miss && !all_marked;
  wire sconf = is_snp && |(match & ((req_op == OP_SNI) ? marked : sw_q));

  assign hit_way       = hw;
  assign hit           = is_acc && hit_any;
  assign miss          = is_acc && !hit_any;
  assign overflow      = miss && is_spec && all_marked;
  assign bypass        = miss && !is_spec && all_marked;
  assign fault         = hit && in_region && (req_op == OP_ST) && marked[hw];
  assign writeback     = (hit && (req_op == OP_SST) && !nack_mode && drt_q[hw] && !sw_q[hw])
                       || (alloc && vld_q[victim_way] && drt_q[victim_way]);
  assign conflict      = sconf && !nack_mode;
  assign snoop_nack    = sconf && nack_mode;
  assign snoop_ack_hit = is_snp && hit_any && !sconf;

  function automatic logic [2:0] touch(input logic [2:0] p, input logic [1:0] w);
    logic [2:0] t;
    t = p;
    t[0] = ~w[1];
    if (!w[1]) t[1] = ~w[0];
    else       t[2] = ~w[0];
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0; drt_q <= '0; sr_q <= '0; sw_q <= '0; plru_q <= '0;
      for (int w = 0; w < WAYS; w++) tag_q[w] <= '0;
    end else if (abort) begin
      vld_q <= vld_q & ~sw_q;
      sr_q  <= '0;
      sw_q  <= '0;
    end else if (commit) begin
      sr_q <= '0;
      sw_q <= '0;
    end else begin
      if (hit && !fault) begin
        plru_q <= touch(plru_q, hw);
        if (req_op[0])                          drt_q[hw] <= 1'b1;
        if (req_op == OP_SLD)                   sr_q[hw]  <= 1'b1;
        if (req_op == OP_SST && !nack_mode)     sw_q[hw]  <= 1'b1;
      end
      if (alloc) begin
        vld_q[victim_way] <= 1'b1;
        tag_q[victim_way] <= req_tag;
        drt_q[victim_way] <= req_op[0];
        sr_q[victim_way]  <= (req_op == OP_SLD);
        sw_q[victim_way]  <= (req_op == OP_SST) && !nack_mode;
        plru_q            <= touch(plru_q, victim_way);
      end
      if (is_rel && hit_any && !sw_q[hw]) sr_q[hw] <= 1'b0;
      if (is_snp && req_op == OP_SNI && hit_any && !sconf) begin
        vld_q[hw] <= 1'b0;
        drt_q[hw] <= 1'b0;
      end
    end
  end

  assert_victim_unmarked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !all_marked) |-> !marked[victim_way]);
  assert_overflow_no_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !abort && !commit) |=> (vld_q == $past(vld_q)));
  assert_bypass_no_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !abort && !commit) |=> (vld_q == $past(vld_q) && sr_q == $past(sr_q) && sw_q == $past(sw_q)));
  assert_fault_drops_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !abort && !commit) |=> (drt_q == $past(drt_q)));
  assert_nack_keeps_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_nack && !abort && !commit) |=> (vld_q == $past(vld_q)));
  assert_commit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (sr_q == '0 && sw_q == '0));
  assert_abort_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ((vld_q & $past(sw_q)) == '0 && sr_q == '0 && sw_q == '0));
endmodule

// File: tb/spec_line_set_tb.sv
module spec_line_set_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_region, nack_mode, commit, abort, req_valid;
  logic [2:0] req_op;
  logic [7:0] req_tag;
  logic hit, miss, overflow, bypass, writeback, fault, conflict, snoop_nack, snoop_ack_hit;
  logic [1:0] hit_way, victim_way;

  spec_line_set #(.TAG_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_region(in_region), .nack_mode(nack_mode),
    .commit(commit), .abort(abort), .req_valid(req_valid), .req_op(req_op),
    .req_tag(req_tag), .hit(hit), .hit_way(hit_way), .miss(miss),
    .victim_way(victim_way), .overflow(overflow), .bypass(bypass),
    .writeback(writeback), .fault(fault), .conflict(conflict),
    .snoop_nack(snoop_nack), .snoop_ack_hit(snoop_ack_hit));

  typedef struct { logic [12:0] exp; bit cv; string name; } item_t;
  item_t q[$];
  item_t mi;
  logic [12:0] got, mask;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  localparam logic [12:0] Z = '0;

  function automatic logic [12:0] mk(bit h, logic [1:0] hw, bit m, logic [1:0] v,
                                     bit o, bit b, bit w, bit f, bit c, bit n, bit a);
    return {h, hw, m, v, o, b, w, f, c, n, a};
  endfunction

  task automatic drive(input bit v, input logic [2:0] op, input logic [7:0] tg,
                       input bit nk, input bit cm, input bit ab,
                       input logic [12:0] e, input bit cv, input string nm);
    item_t it;
    @(negedge clk);
    req_valid = v; req_op = op; req_tag = tg;
    nack_mode = nk; commit = cm; abort = ab;
    it.exp = e; it.cv = cv; it.name = nm;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        mi = q.pop_front();
        got = {hit, hit_way, miss, victim_way, overflow, bypass, writeback,
               fault, conflict, snoop_nack, snoop_ack_hit};
        mask = '1;
        if (!mi.exp[12]) mask[11:10] = 2'b00;
        if (!mi.cv)      mask[8:7]   = 2'b00;
        checks++;
        if ((got & mask) !== (mi.exp & mask)) begin
          fails++;
          $display("FAIL %s: got %b expected %b", mi.name, got & mask, mi.exp & mask);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired before all requirements were checked");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_region = 1'b1; nack_mode = 1'b0; commit = 1'b0; abort = 1'b0;
    req_valid = 1'b0; req_op = '0; req_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 8'h00, 0, 0, 0, Z, 0, "R1 idle outputs after reset");
    drive(1, 0, 8'h10, 0, 0, 0, mk(0,0,1,0,0,0,0,0,0,0,0), 1, "R1 first access misses to way 0");
    drive(1, 0, 8'h10, 0, 0, 0, mk(1,0,0,0,0,0,0,0,0,0,0), 0, "R2 refill then hit way 0");
    drive(1, 1, 8'h20, 0, 0, 0, mk(0,0,1,1,0,0,0,0,0,0,0), 1, "R3 lowest invalid way 1");
    drive(1, 2, 8'h30, 0, 0, 0, mk(0,0,1,2,0,0,0,0,0,0,0), 1, "R3 lowest invalid way 2");
    drive(1, 3, 8'h40, 0, 0, 0, mk(0,0,1,3,0,0,0,0,0,0,0), 1, "R3 lowest invalid way 3");
    drive(1, 0, 8'h50, 0, 0, 0, mk(0,0,1,0,0,0,0,0,0,0,0), 1, "R3 pseudo-LRU picks way 0");
    drive(1, 0, 8'h60, 0, 0, 0, mk(0,0,1,1,0,0,1,0,0,0,0), 1, "R3 R6 other half way 1, dirty victim");
    drive(1, 2, 8'h50, 0, 0, 0, mk(1,0,0,0,0,0,0,0,0,0,0), 0, "R2 speculative load hit way 0");
    drive(1, 2, 8'h60, 0, 0, 0, mk(1,1,0,0,0,0,0,0,0,0,0), 0, "R2 speculative load hit way 1");
    drive(1, 2, 8'h70, 0, 0, 0, mk(0,0,1,0,1,0,0,0,0,0,0), 0, "R4 speculative miss overflows");
    drive(1, 1, 8'h70, 0, 0, 0, mk(0,0,1,0,0,1,0,0,0,0,0), 0, "R5 store miss bypasses");
    drive(1, 0, 8'h70, 0, 0, 0, mk(0,0,1,0,0,1,0,0,0,0,0), 0, "R5 bypassed line not installed");
    drive(1, 1, 8'h30, 0, 0, 0, mk(1,2,0,0,0,0,0,1,0,0,0), 0, "R7 store to marked line faults");
    drive(1, 0, 8'h40, 0, 0, 0, mk(1,3,0,0,0,0,0,0,0,0,0), 0, "R7 load of marked line allowed");
    drive(1, 5, 8'h30, 0, 0, 0, mk(0,0,0,0,0,0,0,0,0,0,1), 0, "R13 keeping snoop on read mark");
    drive(1, 5, 8'h40, 0, 0, 0, mk(0,0,0,0,0,0,0,0,1,0,0), 0, "R8 keeping snoop on write mark");
    drive(1, 6, 8'h30, 1, 0, 0, mk(0,0,0,0,0,0,0,0,0,1,0), 0, "R9 nack instead of conflict");
    drive(1, 0, 8'h30, 0, 0, 0, mk(1,2,0,0,0,0,0,0,0,0,0), 0, "R9 nacked line still present");
    drive(1, 3, 8'h50, 0, 0, 0, mk(1,0,0,0,0,0,0,0,0,0,0), 0, "R6 speculative store to clean line");
    drive(1, 4, 8'h50, 0, 0, 0, Z, 0, "R12 release of write-marked line");
    drive(1, 5, 8'h50, 0, 0, 0, mk(0,0,0,0,0,0,0,0,1,0,0), 0, "R12 ignored release keeps marks");
    drive(1, 4, 8'h30, 0, 0, 0, Z, 0, "R12 release of read-marked line");
    drive(1, 6, 8'h30, 0, 0, 0, mk(0,0,0,0,0,0,0,0,0,0,1), 0, "R12 R13 released line no conflict");
    drive(1, 0, 8'h30, 0, 0, 0, mk(0,0,1,2,0,0,0,0,0,0,0), 1, "R13 invalidated line misses");
    drive(0, 0, 8'h00, 0, 1, 0, Z, 0, "R10 commit cycle quiet");
    drive(1, 5, 8'h40, 0, 0, 0, mk(0,0,0,0,0,0,0,0,0,0,1), 0, "R10 marks cleared, line kept");
    drive(1, 3, 8'h40, 0, 0, 0, mk(1,3,0,0,0,0,1,0,0,0,0), 0, "R6 speculative store on dirty line");
    drive(1, 2, 8'h50, 0, 0, 0, mk(1,0,0,0,0,0,0,0,0,0,0), 0, "R11 read mark before abort");
    drive(1, 3, 8'h60, 1, 0, 0, mk(1,1,0,0,0,0,0,0,0,0,0), 0, "R9 store in nack mode");
    drive(1, 5, 8'h60, 0, 0, 0, mk(0,0,0,0,0,0,0,0,0,0,1), 0, "R9 nack-mode store set no write mark");
    drive(1, 5, 8'h40, 0, 0, 0, mk(0,0,0,0,0,0,0,0,1,0,0), 0, "R8 write mark conflicts");
    drive(0, 0, 8'h00, 0, 0, 1, Z, 0, "R11 abort cycle quiet");
    drive(1, 0, 8'h40, 0, 0, 0, mk(0,0,1,3,0,0,0,0,0,0,0), 1, "R11 write-marked line dropped");
    drive(1, 0, 8'h50, 0, 0, 0, mk(1,0,0,0,0,0,0,0,0,0,0), 0, "R11 read-marked line kept");
    drive(1, 6, 8'h50, 0, 0, 0, mk(0,0,0,0,0,0,0,0,0,0,1), 0, "R11 marks cleared by abort");
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule